// File: doc/BRIEF.md
# Packed-Lane Modular Vector Multiplier

This unit multiplies two 256-bit vectors lane by lane, treating each vector either as sixteen 16-bit elements or as eight 32-bit elements. All the arithmetic runs on one 64x64-bit multiplier. That multiplier can be steered to produce four independent 16x16 products, two independent 32x32 products, or one full 64x64 product, depending on which of its 16x16 partial products it keeps. The unit works through a vector one 64-bit chunk at a time. Each chunk holds four 16-bit or two 32-bit elements, so a 256-bit vector takes four chunks.

There are two arithmetic modes:

- **Plain mode.** Each result lane is the low element-width bits of the lane product. One chunk completes per cycle.
- **Modular mode.** Each lane is Montgomery-reduced with R = 2^w, where w is the element width. Reduction sends the same multiplier through three passes per chunk. The first forms the product, the second forms the reduction factor, and the third multiplies that factor by the modulus, adds, shifts and conditionally subtracts.

A lane-broadcast option multiplies every element of the first source by one indexed element of the second source.

The controller is a small state machine:

- `ST_IDLE` moves on `start`. It goes to `ST_PLAIN` when `modular` is 0, and to `ST_M_PROD` when `modular` is 1.
- `ST_PLAIN` returns to `ST_IDLE` after the last chunk. Otherwise it stays and advances the chunk.
- `ST_M_PROD` always moves to `ST_M_TFAC`.
- `ST_M_TFAC` always moves to `ST_M_FOLD`.
- `ST_M_FOLD` returns to `ST_IDLE` after the last chunk. Otherwise it loops back to `ST_M_PROD` for the next chunk.

Top module: `vec_mont_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: A `start` sampled high while idle with `modular`=0 raises `busy` at the next cycle. `done` is then high exactly 4 clock edges after the start edge, in the same cycle that `busy` returns to 0.
- R3: With `modular`=1 the same handshake completes exactly 12 clock edges after the start edge.
- R4: A `start` sampled while `busy` is 1 is ignored. The running operation keeps its operands, its latency and its result.
- R5: Plain mode with 16-bit elements (`elem32`=0): element i occupies bits [16i+15:16i] of the sources and of `result`. Each result element is the low 16 bits of a_i*b_i.
- R6: Plain mode with 32-bit elements (`elem32`=1): element i occupies bits [32i+31:32i]. Each result element is the low 32 bits of a_i*b_i.
- R7: With `lane_mode`=1, every element of `src_a` is multiplied by element `lane_idx` of `src_b`. In 32-bit view only `lane_idx[2:0]` is used and bit 3 is ignored.
- R8: Modular mode with 16-bit elements: given odd q = `modulus[15:0]`, `mont_qinv[15:0]` = -q^-1 mod 2^16, and inputs below q, each element is a*b*2^-16 mod q and lies in [0, q).
- R9: Modular mode with 32-bit elements: given odd q = `modulus`, `mont_qinv` = -q^-1 mod 2^32, and inputs below q, each element is a*b*2^-32 mod q.
- R10: `done` is a single-cycle pulse and is never high together with `busy`.
- R11: While the unit is idle, `result` holds its value regardless of the data inputs, until a new operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| elem32 | input | 1 | Element view: 0 = 16-bit, 1 = 32-bit |
| modular | input | 1 | 1 selects Montgomery reduction |
| lane_mode | input | 1 | 1 broadcasts one element of `src_b` |
| lane_idx | input | 4 | Broadcast element index |
| modulus | input | 32 | Modulus q (low 16 bits in 16-bit view) |
| mont_qinv | input | 32 | -q^-1 mod R |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 256 | Packed result vector, held while idle |

## Verification
Each failure mode shows at the ports within a predictable time:

- **Chunk counter or state register stuck or skipping.** This moves the `done` pulse away from edge 4 or edge 12. A per-cycle model of `busy` and `done` catches it within one operation.
- **Partial-product mask leaking across lanes.** This corrupts the packed result only in lanes whose neighbours carry nonzero high halves. For this reason, all-ones and random operands are run in both element views.
- **Wrong reduction factor or a missed conditional subtraction.** This appears at the `done` cycle as a lane that is at or above q, or that disagrees with a reference built by repeated halving mod q.
- **Capture register that reloads during a run.** This surfaces as a result taken from the stray operands of an ignored `start`.

// File: rtl/vmul_pkg.sv
package vmul_pkg;

    localparam int CHUNK_W = 64;
    localparam int PIECE_W = 16;
    localparam int N_PIECE = CHUNK_W / PIECE_W;
    localparam int PROD_W  = 2 * CHUNK_W;

    typedef enum logic [1:0] {
        SPLIT_16 = 2'd0,
        SPLIT_32 = 2'd1,
        SPLIT_64 = 2'd2
    } split_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PLAIN  = 3'd1,
        ST_M_PROD = 3'd2,
        ST_M_TFAC = 3'd3,
        ST_M_FOLD = 3'd4
    } vstate_e;

    // Low element-width bits of each lane product, packed into one chunk.
    function automatic logic [CHUNK_W-1:0] pack_low(input logic [PROD_W-1:0] prod,
                                                    input logic e32);
        logic [CHUNK_W-1:0] lo16;
        logic [CHUNK_W-1:0] lo32;
        for (int k = 0; k < 4; k++) lo16[16*k +: 16] = prod[32*k +: 16];
        for (int k = 0; k < 2; k++) lo32[32*k +: 32] = prod[64*k +: 32];
        return e32 ? lo32 : lo16;
    endfunction

    // Copy one scalar into every lane of a chunk.
    function automatic logic [CHUNK_W-1:0] spread(input logic [31:0] v, input logic e32);
        return e32 ? {2{v}} : {4{v[15:0]}};
    endfunction

endpackage

// File: rtl/vmul_split_mult.sv
module vmul_split_mult
    import vmul_pkg::*;
(
    input  split_e             mode,
    input  logic [CHUNK_W-1:0] x,
    input  logic [CHUNK_W-1:0] y,
    output logic [PROD_W-1:0]  prod
);

    logic [2*PIECE_W-1:0] pp [N_PIECE][N_PIECE];

    for (genvar gi = 0; gi < N_PIECE; gi++) begin : g_row
        for (genvar gj = 0; gj < N_PIECE; gj++) begin : g_col
            assign pp[gi][gj] = {16'b0, x[PIECE_W*gi +: PIECE_W]} *
                                {16'b0, y[PIECE_W*gj +: PIECE_W]};
        end
    end

    function automatic logic keep_pp(input split_e m, input int i, input int j);
        case (m)
            SPLIT_64: return 1'b1;
            SPLIT_32: return (i / 2) == (j / 2);
            default:  return i == j;
        endcase
    endfunction

    // Cross-lane partial products are dropped so each lane product is exact.
    always_comb begin
        prod = '0;
        for (int i = 0; i < N_PIECE; i++) begin
            for (int j = 0; j < N_PIECE; j++) begin
                if (keep_pp(mode, i, j)) begin
                    prod = prod + ({{(PROD_W-2*PIECE_W){1'b0}}, pp[i][j]} << (PIECE_W*(i+j)));
                end
            end
        end
    end

endmodule

// File: rtl/vmul_operand_sel.sv
module vmul_operand_sel
    import vmul_pkg::*;
#(
    parameter int VEC_W = 256,
    localparam int N_CHUNK = VEC_W / CHUNK_W,
    localparam int CNT_W = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1,
    localparam int IDX_W = $clog2(VEC_W / 16)
) (
    input  logic [VEC_W-1:0]   a_vec,
    input  logic [VEC_W-1:0]   b_vec,
    input  logic [CNT_W-1:0]   chunk,
    input  logic               e32,
    input  logic               lane_mode,
    input  logic [IDX_W-1:0]   lane_idx,
    output logic [CHUNK_W-1:0] a_chunk,
    output logic [CHUNK_W-1:0] b_chunk
);

    logic [31:0] bcast;

    always_comb begin
        a_chunk = a_vec[int'(chunk)*CHUNK_W +: CHUNK_W];
        if (e32) bcast = b_vec[int'(lane_idx[IDX_W-2:0])*32 +: 32];
        else     bcast = {16'b0, b_vec[int'(lane_idx)*16 +: 16]};
        b_chunk = lane_mode ? spread(bcast, e32) : b_vec[int'(chunk)*CHUNK_W +: CHUNK_W];
    end

endmodule

// File: rtl/vmul_fold.sv
module vmul_fold
    import vmul_pkg::*;
(
    input  logic [PROD_W-1:0]  p,
    input  logic [PROD_W-1:0]  tq,
    input  logic [31:0]        q,
    input  logic               e32,
    output logic [CHUNK_W-1:0] r
);

    logic [CHUNK_W-1:0] r16;
    logic [CHUNK_W-1:0] r32;

    for (genvar g = 0; g < 4; g++) begin : g_h
        logic [32:0] s;
        logic [16:0] u;
        assign s = {1'b0, p[32*g +: 32]} + {1'b0, tq[32*g +: 32]};
        assign u = s[32:16];
        assign r16[16*g +: 16] = (u >= {1'b0, q[15:0]}) ? 16'(u - {1'b0, q[15:0]}) : u[15:0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_w
        logic [64:0] s;
        logic [32:0] u;
        assign s = {1'b0, p[64*g +: 64]} + {1'b0, tq[64*g +: 64]};
        assign u = s[64:32];
        assign r32[32*g +: 32] = (u >= {1'b0, q}) ? 32'(u - {1'b0, q}) : u[31:0];
    end

    assign r = e32 ? r32 : r16;

endmodule

// File: rtl/vec_mont_mul.sv
module vec_mont_mul
    import vmul_pkg::*;
#(
    parameter int VEC_W = 256,
    localparam int N_CHUNK = VEC_W / CHUNK_W,
    localparam int CNT_W = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1,
    localparam int IDX_W = $clog2(VEC_W / 16)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             elem32,
    input  logic             modular,
    input  logic             lane_mode,
    input  logic [IDX_W-1:0] lane_idx,
    input  logic [31:0]      modulus,
    input  logic [31:0]      mont_qinv,
    output logic             busy,
    output logic             done,
    output logic [VEC_W-1:0] result
);

    vstate_e            state_q, state_d;
    logic [CNT_W-1:0]   chunk_q;
    logic               last_chunk;
    logic               accept;

    logic [VEC_W-1:0]   a_q, b_q;
    logic               e32_q, lane_q;
    logic [IDX_W-1:0]   idx_q;
    logic [31:0]        q_q, qinv_q;
    logic [PROD_W-1:0]  p_q;
    logic [CHUNK_W-1:0] t_q;

    logic [CHUNK_W-1:0] a_chunk, b_chunk;
    logic [CHUNK_W-1:0] mul_x, mul_y;
    logic [PROD_W-1:0]  mul_p;
    logic [CHUNK_W-1:0] fold_r;
    split_e             mul_mode;

    logic               done_q;
    logic [VEC_W-1:0]   res_q;

    assign accept     = (state_q == ST_IDLE) && start;
    assign last_chunk = (chunk_q == CNT_W'(N_CHUNK - 1));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = modular ? ST_M_PROD : ST_PLAIN;
            ST_PLAIN:  if (last_chunk) state_d = ST_IDLE;
            ST_M_PROD: state_d = ST_M_TFAC;
            ST_M_TFAC: state_d = ST_M_FOLD;
            ST_M_FOLD: state_d = last_chunk ? ST_IDLE : ST_M_PROD;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and chunk walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chunk_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)                              chunk_q <= '0;
            else if (state_q == ST_PLAIN || state_q == ST_M_FOLD) chunk_q <= chunk_q + 1'b1;
        end
    end

    // Operand capture on accept; intermediate Montgomery terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            e32_q  <= 1'b0;
            lane_q <= 1'b0;
            idx_q  <= '0;
            q_q    <= '0;
            qinv_q <= '0;
            p_q    <= '0;
            t_q    <= '0;
        end else begin
            if (accept) begin
                a_q    <= src_a;
                b_q    <= src_b;
                e32_q  <= elem32;
                lane_q <= lane_mode;
                idx_q  <= lane_idx;
                q_q    <= modulus;
                qinv_q <= mont_qinv;
            end
            if (state_q == ST_M_PROD) p_q <= mul_p;
            if (state_q == ST_M_TFAC) t_q <= pack_low(mul_p, e32_q);
        end
    end

    vmul_operand_sel #(.VEC_W(VEC_W)) u_sel (
        .a_vec     (a_q),
        .b_vec     (b_q),
        .chunk     (chunk_q),
        .e32       (e32_q),
        .lane_mode (lane_q),
        .lane_idx  (idx_q),
        .a_chunk   (a_chunk),
        .b_chunk   (b_chunk)
    );

    // The single multiplier is time-shared across the three reduction passes.
    always_comb begin
        mul_mode = e32_q ? SPLIT_32 : SPLIT_16;
        unique case (state_q)
            ST_M_TFAC: begin
                mul_x = pack_low(p_q, e32_q);
                mul_y = spread(qinv_q, e32_q);
            end
            ST_M_FOLD: begin
                mul_x = t_q;
                mul_y = spread(q_q, e32_q);
            end
            default: begin
                mul_x = a_chunk;
                mul_y = b_chunk;
            end
        endcase
    end

    vmul_split_mult u_mult (
        .mode (mul_mode),
        .x    (mul_x),
        .y    (mul_y),
        .prod (mul_p)
    );

    vmul_fold u_fold (
        .p   (p_q),
        .tq  (mul_p),
        .q   (q_q),
        .e32 (e32_q),
        .r   (fold_r)
    );

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= ((state_q == ST_PLAIN) || (state_q == ST_M_FOLD)) && last_chunk;
            if (state_q == ST_PLAIN)
                res_q[int'(chunk_q)*CHUNK_W +: CHUNK_W] <= pack_low(mul_p, e32_q);
            else if (state_q == ST_M_FOLD)
                res_q[int'(chunk_q)*CHUNK_W +: CHUNK_W] <= fold_r;
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = res_q;

endmodule

// File: rtl/vmul_checker.sv
module vmul_checker #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             elem32,
    input logic             modular,
    input logic [31:0]      modulus,
    input logic             busy,
    input logic             done,
    input logic [VEC_W-1:0] result
);

    logic        mod_cap, e32_cap;
    logic [31:0] q_cap;
    logic [4:0]  lat_cnt;
    logic        over_range;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_cap <= 1'b0;
            e32_cap <= 1'b0;
            q_cap   <= '0;
            lat_cnt <= '0;
        end else if (start && !busy) begin
            mod_cap <= modular;
            e32_cap <= elem32;
            q_cap   <= modulus;
            lat_cnt <= '0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 5'd1;
        end
    end

    always_comb begin
        over_range = 1'b0;
        if (e32_cap) begin
            for (int i = 0; i < VEC_W/32; i++)
                if (result[32*i +: 32] >= q_cap) over_range = 1'b1;
        end else begin
            for (int i = 0; i < VEC_W/16; i++)
                if (result[16*i +: 16] >= q_cap[15:0]) over_range = 1'b1;
        end
    end

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_plain_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mod_cap) |-> (lat_cnt == 5'd4));

    assert_mod_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mod_cap) |-> (lat_cnt == 5'd12));

    assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat_cnt < (mod_cap ? 5'd12 : 5'd4)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));

    assert_mod_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mod_cap) |-> !over_range);

endmodule

bind vec_mont_mul vmul_checker #(.VEC_W(VEC_W)) u_vmul_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .elem32  (elem32),
    .modular (modular),
    .modulus (modulus),
    .busy    (busy),
    .done    (done),
    .result  (result)
);

// File: tb/tb_vec_mont_mul.sv
module tb_vec_mont_mul;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic         elem32 = 1'b0;
    logic         modular = 1'b0;
    logic         lane_mode = 1'b0;
    logic [3:0]   lane_idx = '0;
    logic [31:0]  modulus = 32'd1;
    logic [31:0]  mont_qinv = '0;
    logic         busy, done;
    logic [255:0] result;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // Behavioural model state.
    bit           m_busy = 0, m_done = 0, m_mod = 0;
    int           m_left = 0;
    logic [255:0] m_res = '0, m_pending = '0;
    bit           cmp_on = 0;

    always #4 clk = ~clk;

    vec_mont_mul dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
        .elem32(elem32), .modular(modular), .lane_mode(lane_mode), .lane_idx(lane_idx),
        .modulus(modulus), .mont_qinv(mont_qinv), .busy(busy), .done(done), .result(result)
    );

    function automatic longint unsigned ref_elem(longint unsigned a, longint unsigned b,
                                                 bit e32, bit md, longint unsigned q);
        longint unsigned x;
        if (!md) return e32 ? ((a * b) & 64'hFFFF_FFFF) : ((a * b) & 64'hFFFF);
        x = (a * b) % q;
        repeat (e32 ? 32 : 16) x = x[0] ? ((x + q) >> 1) : (x >> 1);
        return x;
    endfunction

    function automatic logic [255:0] ref_vec(logic [255:0] a, logic [255:0] b, bit e32,
                                            bit md, bit ln, logic [3:0] idx, logic [31:0] q);
        logic [255:0] r = '0;
        if (e32) begin
            for (int i = 0; i < 8; i++) begin
                longint unsigned bi = ln ? b[32*idx[2:0] +: 32] : b[32*i +: 32];
                r[32*i +: 32] = 32'(ref_elem(a[32*i +: 32], bi, 1, md, q));
            end
        end else begin
            for (int i = 0; i < 16; i++) begin
                longint unsigned bi = ln ? b[16*idx +: 16] : b[16*i +: 16];
                r[16*i +: 16] = 16'(ref_elem(a[16*i +: 16], bi, 0, md, {16'b0, q[15:0]}));
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] neg_inv(logic [31:0] q);
        logic [31:0] x = 32'd1;
        repeat (5) x = x * (32'd2 - q * x);
        return -x;
    endfunction

    task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_res = '0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_res = m_pending;
                end
            end else if (start) begin
                m_busy = 1;
                m_mod = modular;
                m_left = modular ? 12 : 4;
                m_pending = ref_vec(src_a, src_b, elem32, modular, lane_mode, lane_idx, modulus);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(busy === m_busy, m_mod ? "R3 busy" : "R2 busy", 256'(busy), 256'(m_busy));
            check(done === m_done, m_mod ? "R3 done" : "R2 done", 256'(done), 256'(m_done));
            check(!(busy && done), "R10", 256'({busy, done}), 256'(0));
            if (!m_busy) check(result === m_res, cur_req, result, m_res);
        end
    end

    task automatic drive(logic [255:0] a, logic [255:0] b, bit e32, bit md, bit ln,
                         logic [3:0] idx, logic [31:0] q);
        src_a = a; src_b = b; elem32 = e32; modular = md; lane_mode = ln;
        lane_idx = idx; modulus = q; mont_qinv = neg_inv(q);
    endtask

    task automatic run_op(logic [255:0] a, logic [255:0] b, bit e32, bit md, bit ln,
                          logic [3:0] idx, logic [31:0] q, string req);
        @(negedge clk);
        cur_req = req;
        drive(a, b, e32, md, ln, idx, q);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] rnd_below(bit e32, logic [31:0] q);
        logic [255:0] v = '0;
        if (e32) for (int i = 0; i < 8; i++)  v[32*i +: 32] = $urandom % q;
        else     for (int i = 0; i < 16; i++) v[16*i +: 16] = 16'($urandom % q);
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] qm16, qm32;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy === 1'b0, "R1 busy", 256'(busy), 256'(0));
        check(done === 1'b0, "R1 done", 256'(done), 256'(0));
        check(result === '0, "R1 result", result, '0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R5: plain 16-bit
        run_op({256{1'b1}}, {256{1'b1}}, 0, 0, 0, 0, 32'd1, "R5");
        for (int k = 0; k < 4; k++) run_op(rnd_vec(), rnd_vec(), 0, 0, 0, 0, 32'd1, "R5");
        // R6: plain 32-bit
        run_op({256{1'b1}}, {256{1'b1}}, 1, 0, 0, 0, 32'd1, "R6");
        for (int k = 0; k < 4; k++) run_op(rnd_vec(), rnd_vec(), 1, 0, 0, 0, 32'd1, "R6");
        // R7: lane broadcast
        run_op(rnd_vec(), rnd_vec(), 0, 0, 1, 4'd15, 32'd1, "R7");
        run_op(rnd_vec(), rnd_vec(), 0, 0, 1, 4'd0, 32'd1, "R7");
        run_op(rnd_vec(), rnd_vec(), 1, 0, 1, 4'd7, 32'd1, "R7");
        run_op(rnd_vec(), rnd_vec(), 1, 0, 1, 4'd11, 32'd1, "R7");
        // R8: modular 16-bit, q = 3329
        qm16 = {16{16'd3328}};
        run_op(qm16, qm16, 0, 1, 0, 0, 32'd3329, "R8");
        run_op('0, qm16, 0, 1, 0, 0, 32'd3329, "R8");
        for (int k = 0; k < 3; k++)
            run_op(rnd_below(0, 3329), rnd_below(0, 3329), 0, 1, 0, 0, 32'd3329, "R8");
        run_op(rnd_below(0, 3329), rnd_below(0, 3329), 0, 1, 1, 4'd9, 32'd3329, "R8");
        // R9: modular 32-bit, q = 8380417
        qm32 = {8{32'd8380416}};
        run_op(qm32, qm32, 1, 1, 0, 0, 32'd8380417, "R9");
        for (int k = 0; k < 3; k++)
            run_op(rnd_below(1, 8380417), rnd_below(1, 8380417), 1, 1, 0, 0, 32'd8380417, "R9");
        run_op(rnd_below(1, 32'hFFFF_FFFB), rnd_below(1, 32'hFFFF_FFFB), 1, 1, 0, 0,
               32'hFFFF_FFFB, "R9");

        // R4: start pulses while busy carry other operands and are ignored
        @(negedge clk);
        cur_req = "R4";
        drive(rnd_vec(), rnd_vec(), 0, 0, 0, 0, 32'd1);
        start = 1'b1;
        @(negedge clk);
        drive(rnd_vec(), rnd_vec(), 1, 1, 0, 0, 32'd8380417);
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
        drive(rnd_below(1, 8380417), rnd_below(1, 8380417), 1, 1, 0, 0, 32'd8380417);
        start = 1'b1;
        repeat (5) @(negedge clk);
        drive(rnd_vec(), rnd_vec(), 0, 0, 1, 4'd3, 32'd1);
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);

        // R2/R3: back-to-back start in the done cycle
        @(negedge clk);
        cur_req = "R2";
        drive(rnd_vec(), rnd_vec(), 1, 0, 0, 0, 32'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        drive(rnd_below(0, 3329), rnd_below(0, 3329), 0, 1, 0, 0, 32'd3329);
        start = 1'b1;
        cur_req = "R3";
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);

        // R11: idle with changing inputs keeps the result
        cur_req = "R11";
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            drive(rnd_vec(), rnd_vec(), k[0], k[1], k[2], 4'(k), 32'd3329);
        end
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule